// File: doc/BRIEF.md
# Translation Lookaside Buffer Lookup

This block is a fully associative address-translation buffer. Every entry holds a virtual page number in a tag store and a physical page number in a parallel data store. A lookup presents a full virtual address. Its page-number part is compared against every valid tag in the same cycle. Each compare produces one match line.

The match lines are not encoded into an index. Each one acts directly as the word select of its own physical page word. The selected word is formed as an AND-OR over all entries. A miss is the NOR of all match lines. The page offset is not translated: it is appended unchanged below the physical page number. The lookup result is registered, so it appears one cycle after the request.

Entries are written through a fill port. The fill port names an entry index and writes a virtual/physical pair into that entry. The choice of victim entry is made outside the block. The software that fills the buffer must never place the same virtual page number in two valid entries.

Top module: `tlbl_top`

## Requirements
- R1: After reset every entry is invalid, all response outputs are 0, and any lookup before the first fill reports a miss.
- R2: A fill (`fill_en`=1) writes `fill_vpn` and `fill_ppn` into entry `fill_idx` and marks that entry valid at the same clock edge. A lookup of that page number in the next cycle hits.
- R3: Lookup results have one cycle of latency: `rsp_valid` in a cycle equals `lk_valid` of the previous cycle.
- R4: On a hit, `rsp_hit`=1 and `rsp_paddr` equals the matching entry's physical page number (upper PPN_W bits) followed by the request offset.
- R5: On a miss, `rsp_miss`=1, `rsp_hit`=0 and the physical page field of `rsp_paddr` is 0. The miss flag is the NOR of all match lines.
- R6: While `rsp_valid`=1, exactly one of `rsp_hit` and `rsp_miss` is 1. While `rsp_valid`=0, `rsp_hit`, `rsp_miss` and `rsp_paddr` are all 0.
- R7: The low OFF_W bits of `rsp_paddr` equal the low OFF_W bits of the request's `lk_vaddr`, on hits and on misses alike.
- R8: Filling an entry that already holds a valid pair replaces that pair. The old page number then misses and the new one hits.
- R9: A lookup in the same cycle as a fill is answered from the contents held before that fill.
- R10: With distinct tags, every entry index from 0 to ENTRIES-1 can be filled and returns its own page. At most one match line is ever asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Write a translation this cycle |
| fill_idx | input | IDX_W | Entry written by the fill |
| fill_vpn | input | VPN_W | Virtual page number to store |
| fill_ppn | input | PPN_W | Physical page number to store |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No entry matched |
| rsp_paddr | output | PPN_W+OFF_W | Physical address: page, then offset |

## Verification
Some properties are checked on every cycle:
- the one-cycle latency of the response;
- the mutual exclusion of hit and miss, and the zeroed outputs when no response is present;
- the miss flag following the NOR of the match lines;
- the offset pass-through;
- the zero page field on a miss;
- the rule that at most one match line is set.

Other behaviours only the scenarios can show, because they depend on what was written earlier:
- that a fill lands in the indexed entry with the right page;
- that a refill displaces the old pair;
- that a lookup sharing a cycle with a fill sees the old contents;
- that every entry index is reachable.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;
  // width of an index over n items, never below one bit
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tlbl_tag_cam.sv
module tlbl_tag_cam #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [VPN_W-1:0]   key,
  output logic [ENTRIES-1:0] match_o
);
  logic [ENTRIES-1:0] valid_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_row
    logic [VPN_W-1:0] tag_q;
    logic             row_wr;
    assign row_wr = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) valid_q[e] <= 1'b0;
      else if (row_wr) valid_q[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (row_wr) tag_q <= wr_vpn;
    end

    // one match line per row: valid and every key bit equal
    assign match_o[e] = valid_q[e] && (tag_q == key);
  end
endmodule

// File: rtl/tlbl_ppn_array.sv
module tlbl_ppn_array #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PPN_W   = 16,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  logic [ENTRIES-1:0] word_sel,
  output logic [PPN_W-1:0]   rd_ppn
);
  logic [PPN_W-1:0] gated [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_word
    logic [PPN_W-1:0] ppn_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(e))) ppn_q <= wr_ppn;
    end
    // the match line is the word select; no encoder in between
    assign gated[e] = ppn_q & {PPN_W{word_sel[e]}};
  end

  always_comb begin
    rd_ppn = '0;
    for (int e = 0; e < ENTRIES; e++) rd_ppn = rd_ppn | gated[e];
  end
endmodule

// File: rtl/tlbl_miss_nor.sv
module tlbl_miss_nor #(
  parameter int unsigned ENTRIES = 8
) (
  input  logic [ENTRIES-1:0] lines,
  output logic               none_o
);
  assign none_o = ~(|lines);
endmodule

// File: rtl/tlbl_top.sv
module tlbl_top #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 16,
  parameter int unsigned OFF_W   = 12,
  localparam int unsigned IDX_W  = tlbl_pkg::idx_bits(ENTRIES),
  localparam int unsigned VA_W   = VPN_W + OFF_W,
  localparam int unsigned PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic [PA_W-1:0]  rsp_paddr
);
  function automatic logic [PA_W-1:0] join_paddr(input logic [PPN_W-1:0] ppn,
                                                 input logic [OFF_W-1:0] off);
    return {ppn, off};
  endfunction

  logic [VPN_W-1:0]   key_vpn;
  logic [OFF_W-1:0]   key_off;
  logic [ENTRIES-1:0] match_line;
  logic               miss_line;
  logic [PPN_W-1:0]   sel_ppn;

  assign key_vpn = lk_vaddr[VA_W-1:OFF_W];
  assign key_off = lk_vaddr[OFF_W-1:0];

  tlbl_tag_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .wr_en(fill_en), .wr_idx(fill_idx),
    .wr_vpn(fill_vpn), .key(key_vpn), .match_o(match_line)
  );

  tlbl_ppn_array #(.ENTRIES(ENTRIES), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_data (
    .clk(clk), .wr_en(fill_en), .wr_idx(fill_idx), .wr_ppn(fill_ppn),
    .word_sel(match_line), .rd_ppn(sel_ppn)
  );

  tlbl_miss_nor #(.ENTRIES(ENTRIES)) u_nor (
    .lines(match_line), .none_o(miss_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && !miss_line;
      rsp_miss  <= lk_valid && miss_line;
      rsp_paddr <= lk_valid ? join_paddr(sel_ppn, key_off) : '0;
    end
  end
endmodule

// File: rtl/tlbl_chk.sv
module tlbl_chk #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PPN_W   = 16,
  parameter int unsigned OFF_W   = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_valid,
  input logic [OFF_W-1:0]       lk_off,
  input logic [ENTRIES-1:0]     match_line,
  input logic                   miss_line,
  input logic                   rsp_valid,
  input logic                   rsp_hit,
  input logic                   rsp_miss,
  input logic [PPN_W+OFF_W-1:0] rsp_paddr
);
  p_latency_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  p_latency_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss));
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_miss && rsp_paddr == '0));
  p_nor_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rsp_miss == $past(miss_line)));
  p_miss_page_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_paddr[PPN_W+OFF_W-1:OFF_W] == '0));
  p_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rsp_paddr[OFF_W-1:0] == $past(lk_off)));
  p_single_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_line));
endmodule

bind tlbl_top tlbl_chk #(.ENTRIES(ENTRIES), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_off(lk_vaddr[OFF_W-1:0]),
  .match_line(match_line), .miss_line(miss_line), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr)
);

// File: tb/sim_tlbl_top.sv
`timescale 1ns/1ps
module sim_tlbl_top;
  localparam int unsigned ENTRIES = 8;
  localparam int unsigned VPN_W   = 20;
  localparam int unsigned PPN_W   = 16;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned VA_W    = VPN_W + OFF_W;
  localparam int unsigned PA_W    = PPN_W + OFF_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fill_en = 1'b0;
  logic [IDX_W-1:0] fill_idx = '0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic             lk_valid = 1'b0;
  logic [VA_W-1:0]  lk_vaddr = '0;
  logic             rsp_valid, rsp_hit, rsp_miss;
  logic [PA_W-1:0]  rsp_paddr;

  always #2.5 clk = ~clk;

  tlbl_top #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u0 (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .lk_valid(lk_valid),
    .lk_vaddr(lk_vaddr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr)
  );

  typedef struct {
    logic            hit;
    logic [PA_W-1:0] paddr;
    string           req;
  } exp_t;

  exp_t             sb[$];
  int               checks = 0;
  int               errors = 0;
  logic [VPN_W-1:0] m_tag [ENTRIES];
  logic [PPN_W-1:0] m_ppn [ENTRIES];
  logic             m_val [ENTRIES];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; the expectation uses the model before the fill
  task automatic step(input bit fe, input int idx, input logic [VPN_W-1:0] fv,
                      input logic [PPN_W-1:0] fp, input bit lv,
                      input logic [VA_W-1:0] va, input string req);
    exp_t e;
    if (lv) begin
      e.hit = 1'b0;
      e.paddr = {{PPN_W{1'b0}}, va[OFF_W-1:0]};
      for (int i = 0; i < ENTRIES; i++)
        if (m_val[i] && m_tag[i] == va[VA_W-1:OFF_W]) begin
          e.hit = 1'b1;
          e.paddr = {m_ppn[i], va[OFF_W-1:0]};
        end
      e.req = req;
      sb.push_back(e);
    end
    if (fe) begin
      m_tag[idx] = fv; m_ppn[idx] = fp; m_val[idx] = 1'b1;
    end
    fill_en = fe; fill_idx = IDX_W'(idx); fill_vpn = fv; fill_ppn = fp;
    lk_valid = lv; lk_vaddr = va;
    @(negedge clk);
    fill_en = 1'b0; lk_valid = 1'b0;
  endtask

  task automatic fill(input int idx, input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p);
    step(1'b1, idx, v, p, 1'b0, '0, "");
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] o, input string req);
    step(1'b0, 0, '0, '0, 1'b1, {v, o}, req);
  endtask

  // monitor: results settle after the edge that registers them
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (rsp_valid) begin
          if (sb.size() == 0) begin
            check(1'b0, "R3", "response without request", 64'(rsp_valid), 64'd0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(rsp_hit == e.hit, e.req, "hit", 64'(rsp_hit), 64'(e.hit));
            check(rsp_miss == !e.hit, e.req, "miss", 64'(rsp_miss), 64'(!e.hit));
            check(rsp_paddr == e.paddr, e.req, "paddr", 64'(rsp_paddr), 64'(e.paddr));
          end
        end else begin
          check(sb.size() == 0, "R3", "response missing", 64'(sb.size()), 64'd0);
          check(!rsp_hit && !rsp_miss && rsp_paddr == '0, "R6", "idle outputs",
                64'({rsp_hit, rsp_miss, rsp_paddr}), 64'd0);
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      m_val[i] = 1'b0; m_tag[i] = '0; m_ppn[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(!rsp_valid && !rsp_hit && !rsp_miss && rsp_paddr == '0, "R1", "reset outputs",
          64'({rsp_valid, rsp_hit, rsp_miss, rsp_paddr}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1, R5: an empty buffer misses everything
    look(20'h00000, 12'h000, "R1");
    look(20'hABCDE, 12'hFFF, "R5");
    // R2, R4, R10: fill every entry with a distinct pair
    for (int i = 0; i < ENTRIES; i++)
      fill(i, 20'h10000 + 20'(i * 7), 16'hA000 + 16'(i * 3));
    for (int i = ENTRIES - 1; i >= 0; i--)
      look(20'h10000 + 20'(i * 7), 12'(i * 291), "R10");
    // R4, R7: hits with edge offsets
    look(20'h10000, 12'hFFF, "R7");
    look(20'h10000 + 20'd49, 12'h001, "R4");
    // R5: an absent page and a near-miss page
    look(20'h10001, 12'h5A5, "R5");
    look(20'h90000, 12'h000, "R5");
    // R3: a gap between lookups
    @(negedge clk);
    look(20'h10000 + 20'd14, 12'h123, "R3");
    // R8: refill entry 3 with a new pair
    fill(3, 20'h55555, 16'h7777);
    look(20'h10000 + 20'd21, 12'h321, "R8");
    look(20'h55555, 12'h321, "R8");
    // R9: fill and lookup in the same cycle see the old contents
    step(1'b1, 5, 20'h66666, 16'h1234, 1'b1, {20'h66666, 12'hABC}, "R9");
    look(20'h66666, 12'hABC, "R2");
    step(1'b1, 6, 20'h77777, 16'h4321, 1'b1, {20'h10000 + 20'd42, 12'h00F}, "R9");
    look(20'h10000 + 20'd42, 12'h00F, "R8");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule